// File: doc/BRIEF.md
# PHY Configuration Packet Transmit Formatter

This block sits between a host write port and the outbound path of a serial-bus link layer. The host deposits 32-bit quadlets into a transmit window at two fixed offsets. A quadlet written at the first offset whose low half equals the configuration marker (16'h00E0) opens a two-quadlet configuration packet. The block checks the header fields and waits for the host's second quadlet. It then emits the packet as two beats on a valid/ready stream. In the first beat the transaction-code nibble is cleared, so the low half goes out as 16'h0000. The second beat is generated internally as the bitwise inverse of the first beat.

Any quadlet that does not open a configuration packet is forwarded as a single beat, unchanged. A malformed configuration packet is dropped whole, and a one-cycle error pulse is raised. The host writes one quadlet per cycle while `wr_ready` is high. While a beat is waiting downstream, the block accepts no writes.

Top module: `phycfg_txfmt`

## Requirements
- R1: After reset, `tx_valid` is 0, `cfg_err` is 0 and `wr_ready` is 1.
- R2: A quadlet accepted at offset 8'h58 while no packet is open, or accepted at 8'h50 with a low half other than 16'h00E0, appears one cycle later as a single beat with `tx_data` equal to the written value and `tx_last`=1.
- R3: A well-formed configuration packet produces two beats. Beat one is {first[31:16],16'h0000} with `tx_last`=0. Beat two is the bitwise inverse of beat one with `tx_last`=1. Nothing is emitted until the second quadlet has been accepted.
- R4: If the first quadlet carries the marker and has bit 23 (force-root flag) and bit 22 (gap-update flag) both 0, the packet is dropped. `cfg_err` is 1 for exactly the cycle after the write, and no beat is emitted.
- R5: If the first quadlet carries the marker and bits [31:30] are not 2'b00, the packet is dropped with the same error pulse and no beat.
- R6: While a packet is open, a quadlet at 8'h58 that differs from ~{first[31:16],16'h0000} in any bit drops the packet with an error pulse and no beat.
- R7: While `tx_valid`=1 and `tx_ready`=0, `tx_data` and `tx_last` hold their values.
- R8: `wr_ready` is 0 whenever `tx_valid` is 1. Writes presented while `wr_ready`=0 have no effect.
- R9: Writes to offsets other than 8'h50 and 8'h58 have no effect.
- R10: A quadlet accepted at 8'h50 while a packet is open abandons the open packet with an error pulse. The new quadlet is then handled as a fresh first quadlet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | ADDR_W | Host write offset |
| wr_data | input | 32 | Host write quadlet |
| wr_ready | output | 1 | Block can accept a write |
| tx_valid | output | 1 | Outbound beat valid |
| tx_ready | input | 1 | Downstream accepts beat |
| tx_data | output | 32 | Outbound quadlet |
| tx_last | output | 1 | Beat ends a packet |
| cfg_err | output | 1 | One-cycle pulse on a dropped packet |

## Verification
A wrong state value shows at the ports on the next edge. One failure mode is a beat that should not appear, for example after a dropped packet or a stray write. Another is a second beat that is not the inverse of the first. A third is `wr_ready` staying high while a beat waits. Every sweep point is sampled one cycle after its write and after each handshake, so any divergence is caught within two cycles. The sweep covers every root identifier, every header-flag and identifier combination, and single-bit corruption of every bit of the second quadlet.

// File: rtl/phycfg_txfmt.sv
module phycfg_txfmt #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] Q0_ADDR = 8'h50,
  parameter logic [ADDR_W-1:0] Q1_ADDR = 8'h58,
  parameter logic [15:0] MARKER = 16'h00E0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  output logic              wr_ready,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [31:0]       tx_data,
  output logic              tx_last,
  output logic              cfg_err
);

  typedef enum logic [1:0] {IDLE, OPEN, SEND} st_t;
  st_t st;
  logic [31:0] q0;

  logic acc, hit0, hit1, is_mark, hdr_ok;
  logic [31:0] rew;

  assign tx_valid = (st == SEND);
  assign wr_ready = !tx_valid;
  assign acc      = wr_en && wr_ready;
  assign hit0     = acc && (wr_addr == Q0_ADDR);
  assign hit1     = acc && (wr_addr == Q1_ADDR);
  assign is_mark  = (wr_data[15:0] == MARKER);
  assign hdr_ok   = (wr_data[31:30] == 2'b00) && (wr_data[23] || wr_data[22]);
  assign rew      = {wr_data[31:16], 16'h0000};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= IDLE;
      q0      <= '0;
      tx_data <= '0;
      tx_last <= 1'b0;
      cfg_err <= 1'b0;
    end else begin
      cfg_err <= 1'b0;
      case (st)
        IDLE, OPEN: begin
          if (hit0) begin
            if (st == OPEN) cfg_err <= 1'b1;
            if (is_mark) begin
              if (hdr_ok) begin
                q0 <= rew;
                st <= OPEN;
              end else begin
                cfg_err <= 1'b1;
                st      <= IDLE;
              end
            end else begin
              tx_data <= wr_data;
              tx_last <= 1'b1;
              st      <= SEND;
            end
          end else if (hit1) begin
            if (st == OPEN) begin
              if (wr_data == ~q0) begin
                tx_data <= q0;
                tx_last <= 1'b0;
                st      <= SEND;
              end else begin
                cfg_err <= 1'b1;
                st      <= IDLE;
              end
            end else begin
              tx_data <= wr_data;
              tx_last <= 1'b1;
              st      <= SEND;
            end
          end
        end
        default: begin
          if (tx_ready) begin
            if (!tx_last) begin
              tx_data <= ~tx_data;
              tx_last <= 1'b1;
            end else begin
              st <= IDLE;
            end
          end
        end
      endcase
    end
  end

endmodule

module phycfg_txfmt_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_ready,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic [31:0] tx_data,
  input logic        tx_last,
  input logic        cfg_err
);

  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

  // R8
  no_write_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !wr_ready);

  // R3
  second_is_inverse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && !tx_last) |=> (tx_valid && tx_last && tx_data == ~$past(tx_data)));

  // R5
  first_beat_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_last) |-> (tx_data[15:0] == 16'h0000 && tx_data[31:30] == 2'b00
                                && (tx_data[23] || tx_data[22])));

  // R4
  err_not_with_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (!tx_valid || tx_last));

endmodule

bind phycfg_txfmt phycfg_txfmt_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_ready(wr_ready), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last), .cfg_err(cfg_err)
);

// File: tb/phycfg_txfmt_tb.sv
module phycfg_txfmt_tb;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0;
  logic [7:0] wr_addr = 0;
  logic [31:0] wr_data = 0;
  logic wr_ready, tx_valid, tx_ready = 0, tx_last, cfg_err;
  logic [31:0] tx_data;
  int checks = 0, errors = 0, cyc = 0;

  always #10 clk = ~clk;

  phycfg_txfmt u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_ready(wr_ready), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_last(tx_last), .cfg_err(cfg_err)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: act=%0d exp<=150000 cycles", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic idle_chk(input string tag);
    chk({tag, " valid"}, {31'b0, tx_valid}, 0);
    chk({tag, " wr_ready"}, {31'b0, wr_ready}, 1);
  endtask

  task automatic beat(input string tag, input logic [31:0] d, input logic l);
    chk({tag, " valid"}, {31'b0, tx_valid}, 1);
    chk({tag, " data"}, tx_data, d);
    chk({tag, " last"}, {31'b0, tx_last}, {31'b0, l});
    tx_ready = 1;
    @(negedge clk);
    tx_ready = 0;
  endtask

  initial begin
    logic [31:0] q, r;
    logic ok;
    repeat (3) @(negedge clk);
    // R1
    chk("R1 valid", {31'b0, tx_valid}, 0);
    chk("R1 err", {31'b0, cfg_err}, 0);
    chk("R1 wr_ready", {31'b0, wr_ready}, 1);
    rst_n = 1;
    @(negedge clk);

    // R3 R4 R5 sweep
    for (int id = 0; id < 4; id++)
      for (int rt = 0; rt < 4; rt++)
        for (int root = 0; root < 64; root++) begin
          q = {id[1:0], root[5:0], rt[1:0], root[5:0] ^ 6'd21, 16'h00E0};
          r = {q[31:16], 16'h0000};
          ok = (id == 0) && (rt != 0);
          wr(8'h50, q);
          chk("R4 R5 err after first", {31'b0, cfg_err}, {31'b0, !ok});
          chk("R3 no beat before second", {31'b0, tx_valid}, 0);
          @(negedge clk);
          chk("R4 err one cycle", {31'b0, cfg_err}, 0);
          if (ok) begin
            wr(8'h58, ~r);
            chk("R3 err", {31'b0, cfg_err}, 0);
            beat("R3 first", r, 1'b0);
            beat("R3 second", ~r, 1'b1);
          end
          idle_chk("R3 R4 R5 end");
        end

    // R6 single-bit corruption
    for (int b = 0; b < 32; b++) begin
      q = {2'b00, 6'd9, 2'b11, 6'd40, 16'h00E0};
      r = {q[31:16], 16'h0000};
      wr(8'h50, q);
      wr(8'h58, ~r ^ (32'd1 << b));
      chk("R6 err", {31'b0, cfg_err}, 1);
      chk("R6 no beat", {31'b0, tx_valid}, 0);
      @(negedge clk);
      idle_chk("R6 after");
    end

    // R2 passthrough
    for (int i = 0; i < 64; i++) begin
      q = (32'h9E3779B9 * (i + 1)) ^ i;
      if (q[15:0] == 16'h00E0) q[0] = 1;
      wr(8'h50, q);
      chk("R2 err", {31'b0, cfg_err}, 0);
      beat("R2 at 50", q, 1'b1);
      q = {q[31:16], 16'h00E0};
      wr(8'h58, q);
      beat("R2 at 58", q, 1'b1);
      idle_chk("R2 after");
    end

    // R7 R8: stall and ignored write
    wr(8'h50, 32'hDEAD_0001);
    repeat (3) begin
      chk("R8 wr_ready low", {31'b0, wr_ready}, 0);
      wr(8'h50, 32'h1234_5678);
      chk("R7 data held", tx_data, 32'hDEAD_0001);
      chk("R7 last held", {31'b0, tx_last}, 1);
    end
    beat("R7 final", 32'hDEAD_0001, 1'b1);
    idle_chk("R8 ignored write left no beat");
    q = {2'b00, 6'd3, 2'b01, 6'd7, 16'h00E0};
    r = {q[31:16], 16'h0000};
    wr(8'h50, q);
    wr(8'h58, ~r);
    tx_ready = 0;
    @(negedge clk);
    chk("R7 pair held", tx_data, r);
    beat("R7 pair first", r, 1'b0);
    @(negedge clk);
    chk("R7 second held", tx_data, ~r);
    beat("R7 pair second", ~r, 1'b1);

    // R9 other offsets
    for (int a = 0; a < 256; a += 4) begin
      if (a == 8'h50 || a == 8'h58) continue;
      wr(a[7:0], 32'h0000_1111 * a);
      chk("R9 no beat", {31'b0, tx_valid}, 0);
      chk("R9 no err", {31'b0, cfg_err}, 0);
    end
    q = {2'b00, 6'd5, 2'b10, 6'd1, 16'h00E0};
    r = {q[31:16], 16'h0000};
    wr(8'h50, q);
    wr(8'h5C, ~r);
    chk("R9 open packet kept", {31'b0, tx_valid}, 0);
    wr(8'h58, ~r);
    beat("R9 first", r, 1'b0);
    beat("R9 second", ~r, 1'b1);

    // R10 restart while open
    wr(8'h50, {2'b00, 6'd1, 2'b11, 6'd2, 16'h00E0});
    q = {2'b00, 6'd60, 2'b01, 6'd33, 16'h00E0};
    r = {q[31:16], 16'h0000};
    wr(8'h50, q);
    chk("R10 err", {31'b0, cfg_err}, 1);
    chk("R10 no beat", {31'b0, tx_valid}, 0);
    wr(8'h58, ~r);
    chk("R10 err cleared", {31'b0, cfg_err}, 0);
    beat("R10 first", r, 1'b0);
    beat("R10 second", ~r, 1'b1);
    wr(8'h50, {2'b00, 6'd1, 2'b11, 6'd2, 16'h00E0});
    wr(8'h50, 32'hCAFE_F00D);
    chk("R10 err plain", {31'b0, cfg_err}, 1);
    beat("R10 plain", 32'hCAFE_F00D, 1'b1);
    idle_chk("R10 end");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule